// File: doc/BRIEF.md
# Hub Downstream Port Power Manager

This block drives the power switches of the downstream ports of a hub and reports overcurrent faults back to the hub status logic. The hub command logic sends it one-cycle power-on and power-off requests per port. External power switches report overcurrent on active-low inputs. Each of those inputs passes through a debounce counter, so a short spike is never taken as a fault. The block drives one active-low enable per port and exposes three things per port: a powered flag, a filtered overcurrent flag and a sticky overcurrent-change flag.

A mode input selects one of two switching schemes. In individual mode each port is handled on its own: its own requests, its own fault and its own flags. In ganged mode the ports act as one group. A request on any port applies to all of them, a fault on any input removes power from every port, and all status flags read the same. The mode is captured only while reset is asserted, and later changes on the input are ignored.

A fault takes priority over requests. A port that was shut down by a fault stays off until a new power-on request arrives at a time when its filtered fault is no longer active.

Top module: `hub_port_power`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every enable output is high (port unpowered) and every status and change flag is low.
- R2: Each enable output `pwr_en_n[i]` is active low and always driven. It equals the inverse of the powered flag `port_pwr[i]`.
- R3: In individual mode, a power-on request on port i powers port i on the next cycle, and a power-off request turns it off. When both arrive in the same cycle, power-off wins. Other ports are unaffected.
- R4: An overcurrent input is accepted as a fault only after it has been sampled low on 16 consecutive clock edges. A single high sample restarts the count, and a high sample clears an accepted fault on the next edge.
- R5: In individual mode, an accepted fault on port i removes power from port i only, one cycle after acceptance.
- R6: A power-on request is ignored while the port's filtered fault is active. After the fault clears, a new power-on request powers the port.
- R7: The change flag `oc_chg[i]` is set one cycle after a fault is accepted and stays set until a clear pulse `chg_clr[i]`. If a set and a clear arrive in the same cycle, the set wins.
- R8: In ganged mode, a power-on or power-off request on any port applies to all ports, so all enables switch together.
- R9: In ganged mode, an accepted fault on any input removes power from all ports. The filtered-fault and change flags are then equal on every port, and a clear pulse on any port clears them all.
- R10: The mode input is sampled only while reset is asserted (1 = ganged, 0 = individual). Changing it after reset has no effect on behaviour.
- R11: `port_oc[i]` shows the filtered fault of port i in individual mode, and the OR of all filtered faults in ganged mode. It rises on the same edge on which the fault is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low; mode is captured while low |
| gang_mode | input | 1 | 1 = ganged, 0 = individual; sampled in reset only |
| pwr_on_req | input | 4 | Per-port power-on request pulse |
| pwr_off_req | input | 4 | Per-port power-off request pulse |
| oc_n | input | 4 | Overcurrent from external switches, active low |
| chg_clr | input | 4 | Per-port clear pulse for the change flag |
| pwr_en_n | output | 4 | Port power-switch enable, active low |
| port_pwr | output | 4 | Port powered status |
| port_oc | output | 4 | Filtered overcurrent status |
| oc_chg | output | 4 | Sticky overcurrent-change flag |

## Verification
The bench targets a low run of exactly 15 samples followed by a high sample, which must not produce a fault, and a run of exactly 16 samples, which must. An off-by-one in the filter would trip on the first or miss the second. It retries power-on during an active fault: a design that lets the request through would re-power a shorted port. It also places set and clear of the change flag in the same cycle, where a wrong priority would lose a fault report. In ganged mode it flips the mode input after reset and faults a single port: a design that samples the mode at run time would fall back to individual behaviour, and one that does not spread the fault would leave the healthy ports powered.

// File: rtl/hpp_pkg.sv
package hpp_pkg;

  typedef enum logic {
    PM_INDIV = 1'b0,
    PM_GANG  = 1'b1
  } pmode_e;

  // next powered state: fault beats off, off beats on
  function automatic logic next_power(input logic cur, input logic flt,
                                      input logic on, input logic off);
    if (flt)      return 1'b0;
    else if (off) return 1'b0;
    else if (on)  return 1'b1;
    else          return cur;
  endfunction

  // sticky flag: set beats clear
  function automatic logic next_sticky(input logic cur, input logic set,
                                       input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/hpp_oc_filter.sv
module hpp_oc_filter #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_n_i,
  output logic flt_o,
  output logic acc_o
);
  localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run_cnt;
  logic          run_full;

  assign run_full = (run_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      flt_o   <= 1'b0;
      acc_o   <= 1'b0;
    end else if (oc_n_i) begin
      run_cnt <= '0;
      flt_o   <= 1'b0;
      acc_o   <= 1'b0;
    end else begin
      acc_o <= run_full & ~flt_o;
      if (run_full) flt_o   <= 1'b1;
      else          run_cnt <= run_cnt + 1'b1;
    end
  end

  // R4: a fault can only appear after a low sample
  assert_rise_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_o) |-> $past(!oc_n_i));

  // R4: a high sample clears the filtered fault
  assert_high_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oc_n_i |=> !flt_o);

  // R4: acceptance pulse coincides with fault rising
  assert_acc_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |-> flt_o);

endmodule

// File: rtl/hpp_port_slot.sv
module hpp_port_slot
  import hpp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flt_i,
  input  logic acc_i,
  input  logic on_i,
  input  logic off_i,
  input  logic clr_i,
  output logic pwr_o,
  output logic chg_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_o <= 1'b0;
      chg_o <= 1'b0;
    end else begin
      pwr_o <= next_power(pwr_o, flt_i, on_i, off_i);
      chg_o <= next_sticky(chg_o, acc_i, clr_i);
    end
  end

  // R5: a fault removes power next cycle
  assert_fault_powers_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flt_i |=> !pwr_o);

  // R3: a clean on request powers the port
  assert_on_powers_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (on_i && !off_i && !flt_i) |=> pwr_o);

  // R3: off request removes power
  assert_off_powers_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    off_i |=> !pwr_o);

  // R7: acceptance sets the change flag
  assert_chg_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i |=> chg_o);

  // R7: clear without set drops the flag
  assert_chg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !acc_i) |=> !chg_o);

endmodule

// File: rtl/hub_port_power.sv
module hub_port_power
  import hpp_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int FILT_LEN  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gang_mode,
  input  logic [NUM_PORTS-1:0] pwr_on_req,
  input  logic [NUM_PORTS-1:0] pwr_off_req,
  input  logic [NUM_PORTS-1:0] oc_n,
  input  logic [NUM_PORTS-1:0] chg_clr,
  output logic [NUM_PORTS-1:0] pwr_en_n,
  output logic [NUM_PORTS-1:0] port_pwr,
  output logic [NUM_PORTS-1:0] port_oc,
  output logic [NUM_PORTS-1:0] oc_chg
);

  // ganged mode ORs a vector across ports, individual passes it through
  function automatic logic [NUM_PORTS-1:0] spread(input pmode_e m,
                                                  input logic [NUM_PORTS-1:0] v);
    return (m == PM_GANG) ? {NUM_PORTS{|v}} : v;
  endfunction

  pmode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= pmode_e'(gang_mode);
  end

  logic [NUM_PORTS-1:0] flt_raw, acc_raw;
  logic [NUM_PORTS-1:0] flt_eff, acc_eff, on_eff, off_eff, clr_eff;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_filt
    hpp_oc_filter #(.LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .oc_n_i (oc_n[g]),
      .flt_o  (flt_raw[g]),
      .acc_o  (acc_raw[g])
    );
  end

  assign flt_eff = spread(mode_q, flt_raw);
  assign acc_eff = spread(mode_q, acc_raw);
  assign on_eff  = spread(mode_q, pwr_on_req);
  assign off_eff = spread(mode_q, pwr_off_req);
  assign clr_eff = spread(mode_q, chg_clr);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_slot
    hpp_port_slot u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .flt_i (flt_eff[g]),
      .acc_i (acc_eff[g]),
      .on_i  (on_eff[g]),
      .off_i (off_eff[g]),
      .clr_i (clr_eff[g]),
      .pwr_o (port_pwr[g]),
      .chg_o (oc_chg[g])
    );
  end

  assign pwr_en_n = ~port_pwr;
  assign port_oc  = flt_eff;

  // R1: first cycle after reset has everything off
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (port_pwr == '0 && oc_chg == '0 && port_oc == '0));

  // R10: mode never moves while out of reset
  assert_mode_static_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));

  // R8: ganged ports all share one power state
  assert_gang_uniform_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_GANG) |-> (port_pwr == '0 || port_pwr == '1));

  // R9: ganged change flags all equal
  assert_gang_chg_uniform_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_GANG) |-> (oc_chg == '0 || oc_chg == '1));

  // R9: any raw fault in ganged mode drops every port
  assert_gang_fault_all_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_GANG && |flt_raw) |=> (port_pwr == '0));

endmodule

// File: tb/test_hub_port_power.sv
module test_hub_port_power;
  localparam int NP = 4;
  localparam int FL = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          gang_mode = 1'b0;
  logic [NP-1:0] pwr_on_req = '0, pwr_off_req = '0, oc_n = '1, chg_clr = '0;
  logic [NP-1:0] pwr_en_n, port_pwr, port_oc, oc_chg;

  int checks = 0;
  int errors = 0;

  // bench model state
  bit          m_gang;
  int          m_cnt [NP];
  bit [NP-1:0] m_flt, m_acc, m_pwr, m_chg;

  always #4 clk = ~clk;

  hub_port_power #(.NUM_PORTS(NP), .FILT_LEN(FL)) i_hub_port_power (
    .clk(clk), .rst_n(rst_n), .gang_mode(gang_mode),
    .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req), .oc_n(oc_n),
    .chg_clr(chg_clr), .pwr_en_n(pwr_en_n), .port_pwr(port_pwr),
    .port_oc(port_oc), .oc_chg(oc_chg)
  );

  function automatic bit [NP-1:0] grp(input bit g, input bit [NP-1:0] v);
    return g ? {NP{|v}} : v;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_gang = gang_mode;
    for (int i = 0; i < NP; i++) m_cnt[i] = 0;
    m_flt = '0; m_acc = '0; m_pwr = '0; m_chg = '0;
  endtask

  task automatic model_step();
    bit [NP-1:0] ef, ea, eon, eoff, eclr;
    ef = grp(m_gang, m_flt); ea = grp(m_gang, m_acc);
    eon = grp(m_gang, pwr_on_req); eoff = grp(m_gang, pwr_off_req);
    eclr = grp(m_gang, chg_clr);
    for (int i = 0; i < NP; i++) begin
      if (ef[i])        m_pwr[i] = 1'b0;
      else if (eoff[i]) m_pwr[i] = 1'b0;
      else if (eon[i])  m_pwr[i] = 1'b1;
      if (ea[i])         m_chg[i] = 1'b1;
      else if (eclr[i])  m_chg[i] = 1'b0;
      if (oc_n[i]) begin
        m_cnt[i] = 0; m_flt[i] = 1'b0; m_acc[i] = 1'b0;
      end else begin
        m_acc[i] = (m_cnt[i] >= FL - 1) && !m_flt[i];
        if (m_cnt[i] >= FL - 1) m_flt[i] = 1'b1;
        else m_cnt[i]++;
      end
    end
  endtask

  task automatic compare(input string req);
    check(req, "pwr_en_n (R2)", pwr_en_n, ~m_pwr);
    check(req, "port_pwr", port_pwr, m_pwr);
    check(req, "port_oc (R11)", port_oc, grp(m_gang, m_flt));
    check(req, "oc_chg (R7)", oc_chg, m_chg);
  endtask

  // inputs already set; one clock, then compare at falling edge
  task automatic step(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(req);
    pwr_on_req = '0; pwr_off_req = '0; chg_clr = '0;
  endtask

  task automatic do_reset(input bit g);
    @(negedge clk);
    rst_n = 1'b0; gang_mode = g;
    pwr_on_req = '0; pwr_off_req = '0; chg_clr = '0; oc_n = '1;
    repeat (3) @(negedge clk);
    model_reset();
    check("R1", "enables in reset", pwr_en_n, '1);
    rst_n = 1'b1;
    step("R1");
    check("R1", "flags after reset", port_oc | oc_chg | port_pwr, '0);
  endtask

  task automatic rand_run(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < NP; i++)
        if ($urandom_range(39) == 0) oc_n[i] = ~oc_n[i];
      pwr_on_req  = ($urandom_range(3) == 0) ? NP'($urandom) : '0;
      pwr_off_req = ($urandom_range(7) == 0) ? NP'($urandom) : '0;
      chg_clr     = ($urandom_range(7) == 0) ? NP'($urandom) : '0;
      if ($urandom_range(99) == 0) gang_mode = ~gang_mode;  // R10
      step(req);
    end
    oc_n = '1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));

    // individual mode
    do_reset(1'b0);
    pwr_on_req = 4'b0101; step("R3");
    pwr_on_req = 4'b0100; pwr_off_req = 4'b0100; step("R3");
    check("R3", "off wins over on", port_pwr, 4'b0001);
    pwr_on_req = 4'b1111; step("R3");

    // R4: 15 low samples then high: no fault
    oc_n[1] = 1'b0;
    repeat (FL - 1) step("R4");
    oc_n[1] = 1'b1; step("R4");
    check("R4", "no fault after short run", port_oc, 4'b0000);
    check("R4", "power kept after short run", port_pwr, 4'b1111);

    // R4/R5/R11: exactly 16 samples
    oc_n[1] = 1'b0;
    repeat (FL - 1) step("R4");
    check("R4", "not yet accepted", port_oc, 4'b0000);
    step("R11");
    check("R11", "fault accepted at 16", port_oc, 4'b0010);
    step("R5");
    check("R5", "only port 1 off", port_pwr, 4'b1101);
    check("R7", "change flag set", oc_chg, 4'b0010);

    // R6: on ignored during fault
    pwr_on_req = 4'b0010; step("R6");
    check("R6", "on ignored in fault", port_pwr, 4'b1101);
    oc_n[1] = 1'b1; step("R6");
    check("R6", "still off after release", port_pwr, 4'b1101);
    pwr_on_req = 4'b0010; step("R6");
    check("R6", "on after release", port_pwr, 4'b1111);
    check("R7", "flag sticky", oc_chg, 4'b0010);
    chg_clr = 4'b0010; step("R7");
    check("R7", "flag cleared", oc_chg, 4'b0000);

    // R7: set and clear same cycle, set wins
    oc_n[3] = 1'b0;
    repeat (FL) step("R7");
    chg_clr = 4'b1000; step("R7");
    check("R7", "set beats clear", oc_chg, 4'b1000);
    oc_n[3] = 1'b1; step("R7");

    rand_run(3000, "R3 R4 R5 R6 R7 R10 R11");

    // ganged mode
    do_reset(1'b1);
    gang_mode = 1'b0;  // R10: ignored
    pwr_on_req = 4'b1000; step("R8");
    check("R8", "one request powers all", port_pwr, 4'b1111);
    pwr_off_req = 4'b0001; step("R10");
    check("R10", "still ganged after mode flip", port_pwr, 4'b0000);
    pwr_on_req = 4'b0100; step("R8");
    oc_n[2] = 1'b0;
    repeat (FL) step("R9");
    check("R9", "status same on all", port_oc, 4'b1111);
    step("R9");
    check("R9", "all off on one fault", port_pwr, 4'b0000);
    check("R9", "all change flags", oc_chg, 4'b1111);
    oc_n[2] = 1'b1; step("R9");
    chg_clr = 4'b0001; step("R9");
    check("R9", "one clear clears all", oc_chg, 4'b0000);

    rand_run(2000, "R8 R9 R10 R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule